// File: doc/BRIEF.md
# MDIO Management Register Controller

This block gives software a two-register window onto the management registers of an Ethernet PHY over a Clause 22 serial management bus. Software writes one command word that holds the PHY address, the register address, the operation and, for writes, the data. Setting the fire bit in that same word starts the transfer. The controller then builds the whole 64-bit management frame and shifts it out on a divided management clock. On a read it releases the data line at turnaround and captures the sixteen bits the PHY returns.

Progress is visible in two places. The fire bit stays set while the frame is on the wire, and an idle flag in the data register always holds its inverse. Commands that lack the Clause 22 start-code select, or whose operation field is not exactly one of read or write, finish at once. They produce no bus activity.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command register reads 0 and the data register reads 0x0001_0000, with the idle flag (bit 16) set. MDC and the MDIO output enable are low.
- R2: The command register sits at byte offset 0x0 and the data register at 0x4. Only 32-bit accesses (size code 2'b10) take effect. Other sizes and other offsets read as 0 and are ignored on write.
- R3: Writing a command with bit 31 (fire) set, bit 28 (Clause 22 select) set and exactly one of bit 27 (read) or bit 26 (write) set makes fire read 1 and idle read 0. Fire clears and idle sets exactly 64*MDC_DIV+1 clock cycles after the accepting write edge.
- R4: A write command sends, MSB first: 32 ones, start 01, op 01, PHY address (cmd bits 25:21), register address (cmd bits 20:16), turnaround 10, and data (cmd bits 15:0). The output enable is high for all 64 bits.
- R5: A read command drives the first 46 bits (op 10) and releases the output enable from the turnaround onward. It samples 16 bits MSB first on MDC rising edges into data bits 15:0, and leaves data bits 31:17 unchanged.
- R6: A fired command with bit 28 clear is stored with fire already cleared. Idle stays 1 and no MDC edge occurs.
- R7: A fired command whose read and write bits are both 0 or both 1 is handled the same way as in R6. Data bits 15:0 keep their previous value.
- R8: Software writes to the data register change only bits 31:17. Bits 15:0 and the idle flag ignore them.
- R9: A command-register write while fire is set has no effect. The stored fields and the frame in flight are unchanged.
- R10: MDC has a period of MDC_DIV clock cycles and is low when idle. MDIO changes only while MDC is low.
- R11: A data-register write that lands on the completion edge of a read takes effect together with the completion. Bits 31:17 take the software value, bits 15:0 take the sampled value, and idle sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_size_i | input | 2 | Access size, 2'b10 is a full word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data in |

## Verification
Two functions can fall in the same cycle: a software write to the data register and the hardware completion of a read, which updates the same register. The bench fires a read and counts clock edges from the accepting write. It then times a data-register write to hit exactly the edge on which fire clears. It judges the result by reading back the whole register: software bits 31:17, PHY bits 15:0 and the idle flag must all be present together. A second race is a command write issued mid-frame. That write must leave the stored command and the captured frame untouched.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int unsigned FRAME_LEN = 64;
  localparam int unsigned TA_IDX    = 46;
  localparam int unsigned RD_IDX    = 48;
  localparam int unsigned FIRE_B    = 31;
  localparam int unsigned C22_B     = 28;
  localparam int unsigned OPRD_B    = 27;
  localparam int unsigned OPWR_B    = 26;
  localparam int unsigned PHY_LSB   = 21;
  localparam int unsigned REG_LSB   = 16;
  localparam int unsigned IDLE_B    = 16;
  localparam logic [1:0]  SIZE_WORD = 2'b10;

  function automatic logic cmd_valid(input logic c22, input logic rd, input logic wr);
    return c22 && (rd ^ wr);
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic rd, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] dat);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10,
            (rd ? 16'h0000 : dat)};
  endfunction
endpackage

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              done_i,
  input  logic [15:0]       rdval_i,
  output logic [31:0]       cmd_o,
  output logic              start_o
);
  localparam logic [ADDR_W-1:0] CMD_OFS = '0;
  localparam logic [ADDR_W-1:0] DAT_OFS = ADDR_W'(4);

  logic [31:0] cmd_q;
  logic [14:0] upper_q;
  logic [15:0] rd_q;
  logic        start_q;
  logic        word_ok, hit_cmd, hit_dat, wr_ok;

  assign word_ok = sel_i && (size_i == SIZE_WORD);
  assign hit_cmd = word_ok && (addr_i == CMD_OFS);
  assign hit_dat = word_ok && (addr_i == DAT_OFS);
  assign wr_ok   = cmd_valid(wdata_i[C22_B], wdata_i[OPRD_B], wdata_i[OPWR_B]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      upper_q <= '0;
      rd_q    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (done_i) begin
        cmd_q[FIRE_B] <= 1'b0;
        if (cmd_q[OPRD_B]) rd_q <= rdval_i;
      end
      // busy blocks command writes entirely
      if (we_i && hit_cmd && !cmd_q[FIRE_B]) begin
        if (wdata_i[FIRE_B] && !wr_ok) begin
          cmd_q <= {1'b0, wdata_i[30:0]};
        end else begin
          cmd_q   <= wdata_i;
          start_q <= wdata_i[FIRE_B];
        end
      end
      if (we_i && hit_dat) upper_q <= wdata_i[31:17];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_cmd)      rdata_o = cmd_q;
    else if (hit_dat) rdata_o = {upper_q, ~cmd_q[FIRE_B], rd_q};
  end

  assign cmd_o   = cmd_q;
  assign start_o = start_q;
endmodule

// File: rtl/mdio_mgmt_mdc_gen.sv
module mdio_mgmt_mdc_gen #(
  parameter int unsigned MDC_DIV = 8  // even, >= 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HALF = MDC_DIV / 2;
  localparam int unsigned CW   = (MDC_DIV > 2) ? $clog2(MDC_DIV) : 1;
  localparam logic [CW-1:0] LAST   = CW'(MDC_DIV - 1);
  localparam logic [CW-1:0] RISE_C = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i || cnt_q == LAST) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q == RISE_C) mdc_q <= 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = run_i && (cnt_q == RISE_C);
  assign fall_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/mdio_mgmt_serial.sv
module mdio_mgmt_serial
  import mdio_mgmt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdat_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        run_o,
  output logic        done_o,
  output logic        mdio_o,
  output logic        oe_o,
  output logic [15:0] rdval_o
);
  localparam int unsigned IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic                 run_q, rd_q;
  logic [IDX_W-1:0]     idx_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic [15:0]          rsh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      rd_q  <= 1'b0;
      idx_q <= '0;
      sh_q  <= '0;
      rsh_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      rd_q  <= rd_i;
      idx_q <= '0;
      sh_q  <= build_frame(rd_i, phy_i, reg_i, wdat_i);
    end else if (run_q) begin
      if (rise_i && rd_q && idx_q >= IDX_W'(RD_IDX)) rsh_q <= {rsh_q[14:0], mdio_i};
      if (fall_i) begin
        if (idx_q == LAST_IDX) run_q <= 1'b0;
        else                   idx_q <= idx_q + IDX_W'(1);
        sh_q <= {sh_q[FRAME_LEN-2:0], 1'b0};
      end
    end
  end

  assign run_o   = run_q;
  assign done_o  = run_q && fall_i && (idx_q == LAST_IDX);
  assign mdio_o  = run_q && sh_q[FRAME_LEN-1];
  assign oe_o    = run_q && (!rd_q || idx_q < IDX_W'(TA_IDX));
  assign rdval_o = rsh_q;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned MDC_DIV = 8,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [1:0]        bus_size_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic [31:0] cmd_w;
  logic [15:0] rdval_w;
  logic        start_w, done_w, run_w, rise_w, fall_w;

  mdio_mgmt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (bus_sel_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .size_i  (bus_size_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .done_i  (done_w),
    .rdval_i (rdval_w),
    .cmd_o   (cmd_w),
    .start_o (start_w)
  );

  mdio_mgmt_mdc_gen #(.MDC_DIV(MDC_DIV)) u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_w),
    .mdc_o  (mdc_o),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  mdio_mgmt_serial u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .rd_i    (cmd_w[OPRD_B]),
    .phy_i   (cmd_w[PHY_LSB +: 5]),
    .reg_i   (cmd_w[REG_LSB +: 5]),
    .wdat_i  (cmd_w[15:0]),
    .rise_i  (rise_w),
    .fall_i  (fall_w),
    .mdio_i  (mdio_i),
    .run_o   (run_w),
    .done_o  (done_w),
    .mdio_o  (mdio_o),
    .oe_o    (mdio_oe_o),
    .rdval_o (rdval_w)
  );
endmodule

// File: rtl/mdio_mgmt_ctrl_sva.sv
module mdio_mgmt_ctrl_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] cmd_i,
  input logic        run_i,
  input logic        done_i,
  input logic        mdc_i,
  input logic        mdio_i,
  input logic        oe_i
);
  p_run_needs_fire_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cmd_i[31]);

  p_done_clears_fire_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !cmd_i[31]);

  p_oe_drop_only_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(oe_i) && run_i) |-> cmd_i[27]);

  p_quiet_when_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i[31] |-> (!mdc_i && !oe_i));

  p_fields_hold_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i[31] && $past(cmd_i[31])) |-> $stable(cmd_i[30:0]));

  p_mdio_moves_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_i) |-> !mdc_i);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_sva u_sva (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cmd_i  (cmd_w),
  .run_i  (run_w),
  .done_i (done_w),
  .mdc_i  (mdc_o),
  .mdio_i (mdio_o),
  .oe_i   (mdio_oe_o)
);

// File: tb/mdio_mgmt_ctrl_test.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_test;
  localparam int DIV  = 8;
  localparam int XFER = 64 * DIV;
  localparam logic [31:0] FIRE = 32'h8000_0000, C22 = 32'h1000_0000;
  localparam logic [31:0] RD = 32'h0800_0000, WR = 32'h0400_0000;

  logic clk = 0, rst_n = 0;
  logic sel = 0, we = 0;
  logic [2:0] addr = 0;
  logic [1:0] size = 2'b10;
  logic [31:0] wdata = 0, rdata;
  logic mdc, mdio_out, mdio_oe, mdio_in;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  int edge_cnt = 0, oe_cnt = 0;
  logic [63:0] cap = 0;
  logic [15:0] phy_val = 0;
  time t_prev = 0, t_per = 0;

  always #5 clk = ~clk;

  mdio_mgmt_ctrl #(.MDC_DIV(DIV), .ADDR_W(3)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_size_i(size), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio_out),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // PHY model: design samples bit index k while edge_cnt == k
  assign mdio_in = (edge_cnt >= 48 && edge_cnt < 64) ? phy_val[63 - edge_cnt] : 1'b1;

  always @(posedge mdc) begin
    cap = {cap[62:0], mdio_out};
    if (mdio_oe) oe_cnt++;
    edge_cnt++;
    if (t_prev != 0) t_per = $time - t_prev;
    t_prev = $time;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic phy_clear();
    edge_cnt = 0; oe_cnt = 0; cap = 0; t_prev = 0; t_per = 0;
  endtask

  // called at a negedge; consumes one posedge
  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d, input logic [1:0] s = 2'b10);
    sel = 1; we = 1; addr = a; wdata = d; size = s;
    @(negedge clk);
    sel = 0; we = 0; size = 2'b10;
  endtask

  // called at a negedge; consumes no edge
  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d, input logic [1:0] s = 2'b10);
    sel = 1; we = 0; addr = a; size = s;
    #1 d = rdata;
    sel = 0; size = 2'b10;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_rd(0, v); chk(v == 0, "R1 cmd", v, 0);
    bus_rd(4, v); chk(v == 32'h0001_0000, "R1 data", v, 32'h0001_0000);
    chk(mdc == 0, "R1 mdc", mdc, 0);
    chk(mdio_oe == 0, "R1 oe", mdio_oe, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    phy_clear();
    bus_wr(0, FIRE | C22 | WR | 32'h1234, 2'b01);
    repeat (20) @(negedge clk);
    bus_rd(0, v); chk(v == 0, "R2 byte write ignored", v, 0);
    chk(edge_cnt == 0, "R2 no frame", edge_cnt, 0);
    bus_wr(4, 32'hFFFF_FFFF, 2'b00);
    bus_rd(4, v); chk(v == 32'h0001_0000, "R2 short data write ignored", v, 32'h0001_0000);
    bus_rd(4, v, 2'b01); chk(v == 0, "R2 short read zero", v, 0);
    bus_rd(3'd0 + 3'd2, v); chk(v == 0, "R2 unaligned read zero", v, 0);
  endtask

  task automatic t_data_wr();
    logic [31:0] v;
    bus_wr(4, 32'hFFFF_FFFF);
    bus_rd(4, v); chk(v == 32'hFFFF_0000, "R8 only upper bits", v, 32'hFFFF_0000);
    bus_wr(4, 32'h0000_0000);
    bus_rd(4, v); chk(v == 32'h0001_0000, "R8 idle kept", v, 32'h0001_0000);
  endtask

  task automatic t_write_xfer();
    logic [31:0] v, c;
    logic [63:0] exp;
    c = FIRE | C22 | WR | (32'h13 << 21) | (32'h0A << 16) | 32'hBEEF;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'hBEEF};
    phy_clear();
    bus_wr(0, c);
    bus_rd(0, v); chk(v[31] == 1, "R3 fire set", v, c);
    bus_rd(4, v); chk(v[16] == 0, "R3 idle clear", v[16], 0);
    repeat (XFER - 1) @(negedge clk);
    bus_rd(0, v); chk(v[31] == 1, "R3 still busy at last cycle", v[31], 1);
    repeat (2) @(negedge clk);
    bus_rd(0, v); chk(v == (c & ~FIRE), "R3 fire cleared", v, c & ~FIRE);
    bus_rd(4, v); chk(v[16] == 1, "R3 idle set", v[16], 1);
    chk(cap == exp, "R4 write frame", cap, exp);
    chk(oe_cnt == 64, "R4 oe whole frame", oe_cnt, 64);
    chk(edge_cnt == 64, "R10 edge count", edge_cnt, 64);
    chk(t_per == DIV * 10, "R10 mdc period", t_per, DIV * 10);
    chk(mdc == 0, "R10 mdc low when idle", mdc, 0);
  endtask

  task automatic t_read_xfer();
    logic [31:0] v, c;
    logic [45:0] exp;
    c = FIRE | C22 | RD | (32'h01 << 21) | (32'h02 << 16) | 32'h7777;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h01, 5'h02};
    bus_wr(4, 32'h000A_0000);
    phy_clear();
    phy_val = 16'hA55A;
    bus_wr(0, c);
    repeat (XFER + 2) @(negedge clk);
    bus_rd(4, v); chk(v == 32'h000B_A55A, "R5 read data", v, 32'h000B_A55A);
    chk(oe_cnt == 46, "R5 released at turnaround", oe_cnt, 46);
    chk(cap[63:18] == exp, "R5 read header", cap[63:18], exp);
  endtask

  task automatic t_reject(input logic [31:0] c, input string req);
    logic [31:0] v;
    phy_clear();
    bus_wr(0, c);
    bus_rd(0, v); chk(v == (c & ~FIRE), {req, " stored without fire"}, v, c & ~FIRE);
    repeat (3 * DIV) @(negedge clk);
    bus_rd(4, v); chk(v == 32'h000B_A55A, {req, " idle and data kept"}, v, 32'h000B_A55A);
    chk(edge_cnt == 0, {req, " no bus activity"}, edge_cnt, 0);
  endtask

  task automatic t_busy_write();
    logic [31:0] v, c;
    logic [63:0] exp;
    c = FIRE | C22 | WR | (32'h05 << 21) | (32'h1F << 16) | 32'h0F0F;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h05, 5'h1F, 2'b10, 16'h0F0F};
    phy_clear();
    bus_wr(0, c);
    repeat (100) @(negedge clk);
    bus_wr(0, FIRE | C22 | RD | 32'h0000_1111);
    bus_wr(0, 32'h0000_2222);
    bus_rd(0, v); chk(v == c, "R9 busy write ignored", v, c);
    repeat (XFER) @(negedge clk);
    chk(cap == exp, "R9 frame unaffected", cap, exp);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v, c;
    c = FIRE | C22 | RD | (32'h03 << 21) | (32'h04 << 16);
    phy_clear();
    phy_val = 16'h3C96;
    bus_wr(0, c);                 // accept edge E0
    repeat (XFER) @(negedge clk);
    bus_wr(4, 32'hFFFE_0000);     // lands on edge E0+XFER+1, completion edge
    bus_rd(4, v); chk(v == 32'hFFFF_3C96, "R11 write and completion merge", v, 32'hFFFF_3C96);
    bus_rd(0, v); chk(v[31] == 0, "R11 fire cleared", v[31], 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_map();
    t_data_wr();
    t_write_xfer();
    t_read_xfer();
    t_reject(FIRE | RD | 32'h0042_0000, "R6");
    t_reject(FIRE | C22 | 32'h0042_0000, "R7 no op");
    t_reject(FIRE | C22 | RD | WR | 32'h0042_0000, "R7 both ops");
    t_busy_write();
    t_same_cycle();
    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule